// File: doc/BRIEF.md
# UART FIFO Control and Interrupt Identification

This block is the register-side control logic of a 16550-style UART. A write at the control offset sets the FIFO mode and fires one-cycle flush strobes toward the receive and transmit FIFOs. A read at that same offset returns the interrupt identification byte instead. The FIFOs and shift registers live outside. This block only tells them when to empty. Flushes never touch the shift registers.

Two interrupt sources are tracked. The first is a transmit data request. In single-register mode it follows the holding register going empty. In FIFO mode it follows the transmit FIFO falling to half of its depth or below. The second is a modem status change on any of the four modem lines. Each source has its own enable bit and its own clear rule. The identification byte reports only the highest-ranked pending, enabled source. A single interrupt line is high while any enabled source is pending.

Register offsets on the byte bus: 0 is transmit data (write only; its data goes to the FIFO outside), 1 is the interrupt enable register, 2 is the FIFO control register on write and the identification register on read, and 6 is modem status (read only).

Top module: `uart_fifoctl_intid`

## Requirements
- R1: After reset, FIFO mode is off, neither flush strobe is high, the interrupt line is low, and reading offset 2 returns 0x01.
- R2: Writing offset 2 loads FIFO mode from data bit 0. Bits 7:6 of the identification byte read 11 while FIFO mode is on and 00 while it is off.
- R3: Writing offset 2 with data bit 1 set raises `rx_fifo_clr` for exactly the one cycle after the write. The bit is not stored, and writing it as 0 produces no strobe.
- R4: Writing offset 2 with data bit 2 set raises `tx_fifo_clr` for exactly the one cycle after the write. The bit is not stored.
- R5: Data bit 3 of a write to offset 2 has no effect. Writing it causes no strobe, does not change the mode, and leaves the identification byte as it was.
- R6: A write to offset 2 that turns FIFO mode from on to off raises both flush strobes in the following cycle.
- R7: A transmit request becomes pending one cycle after its condition rises. The condition is `hold_empty` in single-register mode, and `tx_level <= TXF_DEPTH/2` in FIFO mode.
- R8: A pending transmit request is cleared by a write to offset 0, or by a read of offset 2 that returns code 0x2.
- R9: A read of offset 2 that reports any other code (for example, while the transmit request is masked) leaves the transmit request pending.
- R10: A change on any modem line sets that line's change flag one cycle later. Only a read of offset 6 clears the flags. That read returns the current lines in bits 7:4 (bit 4 CTS, bit 5 DSR, bit 6 RI, bit 7 DCD) and the change flags in bits 3:0 in the same order.
- R11: The identification code in bits 3:0 is 0x2 for the transmit request, 0x0 for modem status and 0x1 for nothing pending. The transmit request outranks modem status.
- R12: Offset 1 stores a byte that reads back as written. Its bit 1 enables the transmit request and its bit 3 enables modem status. `irq` is high exactly when an enabled source is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as `bus_rd` |
| tx_level | input | LVL_W | Transmit FIFO fill count |
| hold_empty | input | 1 | Transmit holding register empty (single-register mode) |
| modem_lines | input | MODEM_N | Modem lines: bit 0 CTS, bit 1 DSR, bit 2 RI, bit 3 DCD |
| fifo_on | output | 1 | FIFO mode enable to both FIFOs |
| rx_fifo_clr | output | 1 | One-cycle receive FIFO flush |
| tx_fifo_clr | output | 1 | One-cycle transmit FIFO flush |
| irq | output | 1 | Interrupt request |

## Verification
The bench raises both sources together and expects code 0x2 first and 0x0 after the read. A ranker with the order reversed would report modem status while the transmit request is still pending. It masks the transmit request and then reads the identification byte, which catches a design that clears the request on any read rather than only a read that reported it. It steps the transmit level from one above half depth to exactly half, which catches an off-by-one in the threshold compare. It writes the ignored bit 3 and turns FIFO mode off twice in a row: a wrong design would fire a stray flush, or would flush again on a write that changes nothing.

// File: rtl/uart_ic_pkg.sv
package uart_ic_pkg;

    localparam int unsigned BUS_AW = 3;
    localparam int unsigned BUS_DW = 8;

    localparam logic [BUS_AW-1:0] OFS_DATA  = 3'd0;
    localparam logic [BUS_AW-1:0] OFS_IEN   = 3'd1;
    localparam logic [BUS_AW-1:0] OFS_CTRL  = 3'd2;
    localparam logic [BUS_AW-1:0] OFS_MSTAT = 3'd6;

    // enable register bit positions
    localparam int unsigned IEN_TX_BIT = 1;
    localparam int unsigned IEN_MD_BIT = 3;

    typedef enum logic [3:0] {
        ID_MODEM = 4'b0000,
        ID_NONE  = 4'b0001,
        ID_TXREQ = 4'b0010
    } int_id_e;

    // low three bits of a control write; bit 3 is accepted and dropped
    typedef struct packed {
        logic tx_flush;
        logic rx_flush;
        logic fifo_on;
    } ctrl_wr_t;

    typedef struct packed {
        logic tx_clr;
        logic rx_clr;
    } flush_t;

    function automatic logic [BUS_DW-1:0] ident_byte(input logic mode, input logic [3:0] id);
        return {{2{mode}}, 2'b00, id};
    endfunction

endpackage

// File: rtl/uart_ctl_decode.sv
module uart_ctl_decode
    import uart_ic_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_ctrl,
    input  ctrl_wr_t wfields,
    output logic     fifo_on,
    output flush_t   flush
);

    logic   drop;
    flush_t nxt;

    always_comb begin
        // leaving FIFO mode empties both sides so no stale bytes remain
        drop       = wr_ctrl && fifo_on && !wfields.fifo_on;
        nxt.rx_clr = (wr_ctrl && wfields.rx_flush) || drop;
        nxt.tx_clr = (wr_ctrl && wfields.tx_flush) || drop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_on <= 1'b0;
            flush   <= '0;
        end else begin
            flush <= nxt;
            if (wr_ctrl) begin
                fifo_on <= wfields.fifo_on;
            end
        end
    end

endmodule

// File: rtl/uart_txreq_src.sv
module uart_txreq_src #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_on,
    input  logic [LVL_W-1:0] tx_level,
    input  logic             hold_empty,
    input  logic             clr_wr,
    input  logic             clr_ident,
    output logic             cond,
    output logic             pend
);

    localparam logic [LVL_W-1:0] HALF = LVL_W'(DEPTH / 2);

    logic cond_q;
    logic rise;

    always_comb begin
        cond = fifo_on ? (tx_level <= HALF) : hold_empty;
        rise = cond && !cond_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            cond_q <= cond;
            if (rise) begin
                pend <= 1'b1;
            end else if (clr_wr || clr_ident) begin
                pend <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/uart_modem_src.sv
module uart_modem_src #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lines,
    input  logic         clr_rd,
    output logic [N-1:0] delta,
    output logic         pend
);

    logic [N-1:0] prev;
    logic         seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= '0;
            seen <= 1'b0;
        end else begin
            prev <= lines;
            seen <= 1'b1;
        end
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) begin
                    delta[g] <= 1'b0;
                end else if (seen && (lines[g] != prev[g])) begin
                    delta[g] <= 1'b1;
                end else if (clr_rd) begin
                    delta[g] <= 1'b0;
                end
            end
        end
    endgenerate

    assign pend = |delta;

endmodule

// File: rtl/uart_int_rank.sv
module uart_int_rank
    import uart_ic_pkg::*;
#(
    parameter int unsigned         NSRC  = 2,
    parameter logic [4*NSRC-1:0]   CODES = '0
) (
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] en,
    output logic [3:0]      id,
    output logic [NSRC-1:0] sel,
    output logic            any
);

    logic [NSRC-1:0] live;

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_mask
            assign live[g] = pend[g] && en[g];
        end
    endgenerate

    // index 0 ranks highest: walk upward from the lowest rank so it wins last
    always_comb begin
        id  = ID_NONE;
        sel = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (live[i]) begin
                id     = CODES[4*i +: 4];
                sel    = '0;
                sel[i] = 1'b1;
            end
        end
    end

    assign any = |live;

endmodule

// File: rtl/uart_fifoctl_intid.sv
module uart_fifoctl_intid
    import uart_ic_pkg::*;
#(
    parameter int unsigned TXF_DEPTH = 16,
    parameter int unsigned LVL_W     = $clog2(TXF_DEPTH + 1),
    parameter int unsigned MODEM_N   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [BUS_DW-1:0]  bus_wdata,
    output logic [BUS_DW-1:0]  bus_rdata,
    input  logic [LVL_W-1:0]   tx_level,
    input  logic               hold_empty,
    input  logic [MODEM_N-1:0] modem_lines,
    output logic               fifo_on,
    output logic               rx_fifo_clr,
    output logic               tx_fifo_clr,
    output logic               irq
);

    localparam int unsigned NSRC = 2;
    localparam logic [4*NSRC-1:0] RANK_CODES = {4'(ID_MODEM), 4'(ID_TXREQ)};

    logic               wr_ctrl, wr_data, wr_ien;
    logic               rd_ident, rd_mstat;
    logic [BUS_DW-1:0]  ien_q;
    logic               ien_tx, ien_md;
    flush_t             flush;
    logic               tx_cond, tx_pend;
    logic [MODEM_N-1:0] md_delta;
    logic               md_pend;
    logic [3:0]         cur_id;
    logic [NSRC-1:0]    cur_sel;
    logic               any_live;

    always_comb begin
        wr_ctrl  = bus_wr && (bus_addr == OFS_CTRL);
        wr_data  = bus_wr && (bus_addr == OFS_DATA);
        wr_ien   = bus_wr && (bus_addr == OFS_IEN);
        rd_ident = bus_rd && (bus_addr == OFS_CTRL);
        rd_mstat = bus_rd && (bus_addr == OFS_MSTAT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q <= '0;
        end else if (wr_ien) begin
            ien_q <= bus_wdata;
        end
    end

    assign ien_tx = ien_q[IEN_TX_BIT];
    assign ien_md = ien_q[IEN_MD_BIT];

    uart_ctl_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_ctrl),
        .wfields (ctrl_wr_t'(bus_wdata[2:0])),
        .fifo_on (fifo_on),
        .flush   (flush)
    );

    assign rx_fifo_clr = flush.rx_clr;
    assign tx_fifo_clr = flush.tx_clr;

    uart_txreq_src #(
        .DEPTH (TXF_DEPTH),
        .LVL_W (LVL_W)
    ) u_txreq (
        .clk        (clk),
        .rst        (rst),
        .fifo_on    (fifo_on),
        .tx_level   (tx_level),
        .hold_empty (hold_empty),
        .clr_wr     (wr_data),
        .clr_ident  (rd_ident && cur_sel[0]),
        .cond       (tx_cond),
        .pend       (tx_pend)
    );

    uart_modem_src #(
        .N (MODEM_N)
    ) u_modem (
        .clk    (clk),
        .rst    (rst),
        .lines  (modem_lines),
        .clr_rd (rd_mstat),
        .delta  (md_delta),
        .pend   (md_pend)
    );

    uart_int_rank #(
        .NSRC  (NSRC),
        .CODES (RANK_CODES)
    ) u_rank (
        .pend ({md_pend, tx_pend}),
        .en   ({ien_md, ien_tx}),
        .id   (cur_id),
        .sel  (cur_sel),
        .any  (any_live)
    );

    assign irq = any_live;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                OFS_IEN:   bus_rdata = ien_q;
                OFS_CTRL:  bus_rdata = ident_byte(fifo_on, cur_id);
                OFS_MSTAT: bus_rdata = BUS_DW'({modem_lines, md_delta});
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/uart_fifoctl_intid_chk.sv
module uart_fifoctl_intid_chk
    import uart_ic_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              wr_bit0,
    input logic [BUS_DW-1:0] bus_rdata,
    input logic              fifo_on,
    input logic              rx_fifo_clr,
    input logic              tx_fifo_clr,
    input logic              irq,
    input logic              tx_cond,
    input logic              tx_pend,
    input logic              ien_tx,
    input logic              ien_md
);

    p_mode_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == OFS_CTRL) |=> $stable(fifo_on));

    p_mode_ident_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_CTRL) |-> (bus_rdata[7:6] == {2{fifo_on}}));

    p_rx_clr_cause_r3: assert property (@(posedge clk) disable iff (rst)
        rx_fifo_clr |-> $past(bus_wr && bus_addr == OFS_CTRL));

    p_tx_clr_cause_r4: assert property (@(posedge clk) disable iff (rst)
        tx_fifo_clr |-> $past(bus_wr && bus_addr == OFS_CTRL));

    p_drop_flush_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_CTRL && fifo_on && !wr_bit0) |=> (rx_fifo_clr && tx_fifo_clr));

    p_tx_wr_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFS_DATA && !$rose(tx_cond) && !$past(rst)) |=> !tx_pend);

    p_modem_survives_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_CTRL && bus_rdata[3:0] == 4'b0000 && !bus_wr) |=> irq);

    p_tx_first_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_CTRL && tx_pend && ien_tx) |-> (bus_rdata[3:0] == 4'b0010));

    p_code_irq_r12: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_CTRL) |-> (irq == (bus_rdata[3:0] != 4'b0001)));

    p_masked_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (!ien_tx && !ien_md) |-> !irq);

endmodule

bind uart_fifoctl_intid uart_fifoctl_intid_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .wr_bit0     (bus_wdata[0]),
    .bus_rdata   (bus_rdata),
    .fifo_on     (fifo_on),
    .rx_fifo_clr (rx_fifo_clr),
    .tx_fifo_clr (tx_fifo_clr),
    .irq         (irq),
    .tx_cond     (tx_cond),
    .tx_pend     (tx_pend),
    .ien_tx      (ien_tx),
    .ien_md      (ien_md)
);

// File: tb/tb_uart_fifoctl_intid.sv
module tb_uart_fifoctl_intid;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int LW         = $clog2(DEPTH + 1);
    localparam int NV         = 19;

    // vector: {req[30:27], op[26:25], addr[24:22], wdata[21:14], hold[13],
    //          lines[12:9], exp_rdata[8:1], exp_irq[0]}; op 0 idle, 1 write, 2 read
    localparam logic [30:0] VECS [0:NV-1] = '{
        {4'd1,  2'd2, 3'd2, 8'h00, 1'b0, 4'b0000, 8'h01, 1'b0}, // R1 idle ident
        {4'd12, 2'd1, 3'd1, 8'h0A, 1'b0, 4'b0000, 8'h00, 1'b0}, // R12 enable both
        {4'd12, 2'd2, 3'd1, 8'h00, 1'b0, 4'b0000, 8'h0A, 1'b0}, // R12 readback
        {4'd7,  2'd0, 3'd0, 8'h00, 1'b1, 4'b0000, 8'h00, 1'b1}, // R7 holding empty
        {4'd8,  2'd2, 3'd2, 8'h00, 1'b1, 4'b0000, 8'h02, 1'b0}, // R8 ident read clears
        {4'd7,  2'd0, 3'd0, 8'h00, 1'b0, 4'b0000, 8'h00, 1'b0}, // R7 fall
        {4'd7,  2'd0, 3'd0, 8'h00, 1'b1, 4'b0000, 8'h00, 1'b1}, // R7 rise again
        {4'd8,  2'd1, 3'd0, 8'h55, 1'b1, 4'b0000, 8'h00, 1'b0}, // R8 data write clears
        {4'd10, 2'd0, 3'd0, 8'h00, 1'b0, 4'b0001, 8'h00, 1'b1}, // R10 CTS change
        {4'd10, 2'd2, 3'd2, 8'h00, 1'b0, 4'b0001, 8'h00, 1'b1}, // R10 ident read keeps
        {4'd11, 2'd0, 3'd0, 8'h00, 1'b1, 4'b0001, 8'h00, 1'b1}, // R11 both pending
        {4'd11, 2'd2, 3'd2, 8'h00, 1'b1, 4'b0001, 8'h02, 1'b1}, // R11 transmit first
        {4'd11, 2'd2, 3'd2, 8'h00, 1'b1, 4'b0001, 8'h00, 1'b1}, // R11 then modem
        {4'd10, 2'd2, 3'd6, 8'h00, 1'b1, 4'b0001, 8'h11, 1'b0}, // R10 status read clears
        {4'd11, 2'd2, 3'd2, 8'h00, 1'b1, 4'b0001, 8'h01, 1'b0}, // R11 none
        {4'd10, 2'd0, 3'd0, 8'h00, 1'b1, 4'b0101, 8'h00, 1'b1}, // R10 RI change
        {4'd12, 2'd1, 3'd1, 8'h02, 1'b1, 4'b0101, 8'h00, 1'b0}, // R12 mask modem
        {4'd12, 2'd2, 3'd2, 8'h00, 1'b1, 4'b0101, 8'h01, 1'b0}, // R12 masked shows none
        {4'd10, 2'd2, 3'd6, 8'h00, 1'b1, 4'b0101, 8'h54, 1'b0}  // R10 flags kept while masked
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    bus_addr = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic [LW-1:0] tx_level = LW'(DEPTH);
    logic          hold_empty = 1'b0;
    logic [3:0]    modem_lines = '0;
    logic          fifo_on, rx_fifo_clr, tx_fifo_clr, irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_fifoctl_intid #(.TXF_DEPTH(DEPTH)) dut (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .tx_level    (tx_level),
        .hold_empty  (hold_empty),
        .modem_lines (modem_lines),
        .fifo_on     (fifo_on),
        .rx_fifo_clr (rx_fifo_clr),
        .tx_fifo_clr (tx_fifo_clr),
        .irq         (irq)
    );

    task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        d = bus_rdata;
        step();
        bus_rd = 1'b0;
    endtask

    // samples both strobes right after the write edge and one cycle later
    task automatic strobe_chk(input int req, input logic [7:0] d, input logic exp_rx, input logic exp_tx);
        bus_write(3'd2, d);
        chk(req, "rx strobe first cycle", {7'd0, rx_fifo_clr}, {7'd0, exp_rx});
        chk(req, "tx strobe first cycle", {7'd0, tx_fifo_clr}, {7'd0, exp_tx});
        step();
        chk(req, "strobes self-clear", {6'd0, rx_fifo_clr, tx_fifo_clr}, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog: actual=%h expected=%h", 8'h00, 8'h01);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;

        // R1 reset state
        chk(1, "fifo_on after reset", {7'd0, fifo_on}, 8'h00);
        chk(1, "strobes after reset", {6'd0, rx_fifo_clr, tx_fifo_clr}, 8'h00);
        chk(1, "irq after reset", {7'd0, irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [30:0] v;
            v           = VECS[i];
            hold_empty  = v[13];
            modem_lines = v[12:9];
            bus_addr    = v[24:22];
            bus_wdata   = v[21:14];
            bus_wr      = (v[26:25] == 2'd1);
            bus_rd      = (v[26:25] == 2'd2);
            #1;
            if (v[26:25] == 2'd2) chk(int'(v[30:27]), $sformatf("vec %0d rdata", i), bus_rdata, v[8:1]);
            step();
            bus_wr = 1'b0;
            bus_rd = 1'b0;
            chk(int'(v[30:27]), $sformatf("vec %0d irq", i), {7'd0, irq}, {7'd0, v[0]});
        end

        // R2: enter FIFO mode, ident bits 7:6 follow
        strobe_chk(2, 8'h01, 1'b0, 1'b0);
        chk(2, "fifo_on set", {7'd0, fifo_on}, 8'h01);
        bus_read(3'd2, rd);
        chk(2, "ident in FIFO mode", rd, 8'hC1);

        // R3, R4 flush strobes; mode stays on
        strobe_chk(3, 8'h03, 1'b1, 1'b0);
        chk(3, "mode kept after rx flush", {7'd0, fifo_on}, 8'h01);
        strobe_chk(4, 8'h05, 1'b0, 1'b1);

        // R5 bit 3 ignored
        strobe_chk(5, 8'h09, 1'b0, 1'b0);
        chk(5, "mode after bit3 write", {7'd0, fifo_on}, 8'h01);
        bus_read(3'd2, rd);
        chk(5, "ident after bit3 write", rd, 8'hC1);

        // R7 threshold at half depth in FIFO mode
        tx_level = LW'(DEPTH / 2 + 1);
        step();
        chk(7, "level above half", {7'd0, irq}, 8'h00);
        tx_level = LW'(DEPTH / 2);
        step();
        chk(7, "level at half", {7'd0, irq}, 8'h01);
        bus_read(3'd2, rd);
        chk(8, "ident reports transmit", rd, 8'hC2);
        chk(8, "cleared by ident read", {7'd0, irq}, 8'h00);

        // R9 masked transmit request survives an ident read
        tx_level = LW'(DEPTH);
        step();
        bus_write(3'd1, 8'h08);
        tx_level = LW'(DEPTH / 2);
        step();
        chk(9, "masked request quiet", {7'd0, irq}, 8'h00);
        bus_read(3'd2, rd);
        chk(9, "ident while masked", rd, 8'hC1);
        bus_write(3'd1, 8'h0A);
        chk(9, "unmasked request pending", {7'd0, irq}, 8'h01);
        bus_read(3'd2, rd);
        chk(9, "ident after unmask", rd, 8'hC2);
        chk(8, "cleared after report", {7'd0, irq}, 8'h00);

        // R6 leaving FIFO mode flushes both, only on a real change
        tx_level = LW'(DEPTH);
        strobe_chk(6, 8'h00, 1'b1, 1'b1);
        chk(6, "mode off", {7'd0, fifo_on}, 8'h00);
        strobe_chk(6, 8'h00, 1'b0, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule